// File: doc/BRIEF.md
# Flash Array Busy and Status Controller

This block sits behind the serial command parser of a page-organised flash device. The parser hands it one launch request per decoded command, carrying an operation code and a target page. Commands that use the memory array start an internal cycle timer, and the block reports busy for as long as that timer runs. Buffer-only commands and status reads never touch the timer and are accepted at any time, busy or not. While busy, any further array command is dropped without effect. When the write-protect input is low, program and erase commands aimed at the low protected page range are discarded.

The block keeps the result of the last page-versus-buffer compare. The comparison itself is done elsewhere; its result arrives on `cmp_mismatch` and is captured in the cycle the compare timer expires. A serialiser sends the status byte one bit per shift strobe, most significant bit first, and loops for as long as the parser keeps shifting. Every new pass takes a fresh snapshot of the status. The ready/busy pin is modelled as an active-high enable for an external open-drain pull-down.

Top module: `flash_busy_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block is idle: `rdy_pull_oe` is 0, the ready bit reads 1 and the compare bit reads 0.
- R2: An accepted array command (codes 1 transfer, 2 compare, 3 program with erase, 4 program only, 5 page erase, 6 block erase, 7 program through buffer, 8 auto rewrite, 9 page read) drives `rdy_pull_oe` high from the cycle after launch, for exactly its cycle count.
- R3: The cycle counts are `CYC_XFER` for codes 1, 2 and 9; `CYC_EP` for codes 3, 7 and 8; `CYC_PGM` for code 4; `CYC_PE` for code 5; `CYC_BE` for code 6.
- R4: Codes 10 (buffer read), 11 (buffer write), 12 (status read), 0 and 13 to 15 never make the block busy.
- R5: An array command launched while busy is dropped. The running operation still ends at its original time, and status bit 6 is unchanged.
- R6: Status bit 6 takes the value of `cmp_mismatch` in the cycle a compare's timer expires, and changes at no other time.
- R7: With `wp_n` low, codes 3 to 8 whose page is below `PROT_PAGES` are dropped. Codes 1, 2 and 9 are unaffected.
- R8: The status byte is {ready, compare mismatch, 0, 1, 0, 1, 0, 0}, from bit 7 down to bit 0.
- R9: `stat_load` selects bit 7. Each `stat_shift` moves one bit toward bit 0. A shift at bit 0 returns to bit 7 and takes a fresh snapshot of bits 6..0.
- R10: While bit 7 is selected, `stat_bit` follows the live ready state.
- R11: Taking `rst_n` low during an operation ends it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the device reset |
| launch_valid | input | 1 | One-cycle launch request from the parser |
| launch_op | input | 4 | Operation code of the request |
| launch_page | input | PAGE_W | Target page of the request |
| wp_n | input | 1 | Write protect, active low |
| cmp_mismatch | input | 1 | Compare result from the datapath, 1 when any bit differs |
| stat_load | input | 1 | Start of a status read, selects bit 7 |
| stat_shift | input | 1 | Advance the status serialiser one bit |
| stat_bit | output | 1 | Currently selected status bit |
| rdy_pull_oe | output | 1 | Enable for the open-drain ready/busy pull-down |

## Verification
The assertions assume the parser never presents `stat_load` and `stat_shift` together in a way that matters: load takes precedence. They also assume `cmp_mismatch` is valid in the cycle a compare finishes. The bench drives random operation codes over the full 4-bit range, pages clustered around the protection boundary, and random write-protect and compare values. It issues load and shift strobes at random as well. The timer limits are shortened through parameters so that every class of operation finishes many times within the run.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    typedef enum logic [3:0] {
        OP_NONE    = 4'd0,
        OP_XFER    = 4'd1,
        OP_CMP     = 4'd2,
        OP_PGM_ERS = 4'd3,
        OP_PGM     = 4'd4,
        OP_PERASE  = 4'd5,
        OP_BERASE  = 4'd6,
        OP_PGM_BUF = 4'd7,
        OP_REWRITE = 4'd8,
        OP_PREAD   = 4'd9,
        OP_BUF_RD  = 4'd10,
        OP_BUF_WR  = 4'd11,
        OP_STATUS  = 4'd12
    } op_e;

    typedef enum logic [2:0] {
        TC_NONE,
        TC_XFER,
        TC_EP,
        TC_PGM,
        TC_PE,
        TC_BE
    } tclass_e;

    localparam logic [3:0] DENSITY_CODE = 4'b0101;

endpackage

// File: rtl/fsb_op_decode.sv
module fsb_op_decode
    import flash_stat_pkg::*;
(
    input  logic [3:0] op,
    output logic       is_array,
    output logic       is_prog,
    output tclass_e    tclass
);
    always_comb begin
        is_array = 1'b0;
        is_prog  = 1'b0;
        tclass   = TC_NONE;
        case (op)
            OP_XFER, OP_CMP, OP_PREAD: begin
                is_array = 1'b1;
                tclass   = TC_XFER;
            end
            OP_PGM_ERS, OP_PGM_BUF, OP_REWRITE: begin
                is_array = 1'b1;
                is_prog  = 1'b1;
                tclass   = TC_EP;
            end
            OP_PGM: begin
                is_array = 1'b1;
                is_prog  = 1'b1;
                tclass   = TC_PGM;
            end
            OP_PERASE: begin
                is_array = 1'b1;
                is_prog  = 1'b1;
                tclass   = TC_PE;
            end
            OP_BERASE: begin
                is_array = 1'b1;
                is_prog  = 1'b1;
                tclass   = TC_BE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fsb_op_timer.sv
module fsb_op_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.busy && (st_q.cnt == '0);

    // R5: the launch gate never starts the timer over a running operation
    assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R2: busy holds until the terminal count
    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R2: busy drops right after the terminal count
    assert_done_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/fsb_stat_shift.sv
module fsb_stat_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       shift,
    input  logic [6:0] status_low,
    input  logic       ready_live,
    output logic       bit_out
);
    typedef struct packed {
        logic [2:0] idx;
        logic [6:0] snap;
    } shf_t;

    shf_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.idx  = 3'd7;
            sh_d.snap = status_low;
        end else if (shift) begin
            if (sh_q.idx == 3'd0) begin
                sh_d.idx  = 3'd7;
                sh_d.snap = status_low;
            end else begin
                sh_d.idx  = sh_q.idx - 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '{idx: 3'd7, snap: 7'd0};
        else        sh_q <= sh_d;
    end

    assign bit_out = (sh_q.idx == 3'd7) ? ready_live : sh_q.snap[sh_q.idx];

    // R9: a shift at bit 0 wraps back to bit 7
    assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load && sh_q.idx == 3'd0) |=> (sh_q.idx == 3'd7));

    // R9: a load always selects bit 7
    assert_load_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sh_q.idx == 3'd7));

    // R10: bit 7 tracks the live ready state
    assert_live_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.idx == 3'd7) |-> (bit_out == ready_live));
endmodule

// File: rtl/flash_busy_ctrl.sv
module flash_busy_ctrl
    import flash_stat_pkg::*;
#(
    parameter int PAGE_W     = 10,
    parameter int PROT_PAGES = 256,
    parameter int CYC_XFER   = 12500,
    parameter int CYC_EP     = 1000000,
    parameter int CYC_PGM    = 700000,
    parameter int CYC_PE     = 400000,
    parameter int CYC_BE     = 600000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_valid,
    input  logic [3:0]        launch_op,
    input  logic [PAGE_W-1:0] launch_page,
    input  logic              wp_n,
    input  logic              cmp_mismatch,
    input  logic              stat_load,
    input  logic              stat_shift,
    output logic              stat_bit,
    output logic              rdy_pull_oe
);
    localparam int MAX_A   = (CYC_XFER > CYC_EP) ? CYC_XFER : CYC_EP;
    localparam int MAX_B   = (CYC_PGM > CYC_PE) ? CYC_PGM : CYC_PE;
    localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC = (MAX_AB > CYC_BE) ? MAX_AB : CYC_BE;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        op_e  op;
        logic cmp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             is_array, is_prog;
    tclass_e          tclass;
    logic             busy, done, start, blocked;
    logic [CNT_W-1:0] load_val;
    logic [6:0]       stat_low;

    fsb_op_decode u_dec (
        .op       (launch_op),
        .is_array (is_array),
        .is_prog  (is_prog),
        .tclass   (tclass)
    );

    always_comb begin
        case (tclass)
            TC_XFER: load_val = CNT_W'(CYC_XFER - 1);
            TC_EP:   load_val = CNT_W'(CYC_EP - 1);
            TC_PGM:  load_val = CNT_W'(CYC_PGM - 1);
            TC_PE:   load_val = CNT_W'(CYC_PE - 1);
            TC_BE:   load_val = CNT_W'(CYC_BE - 1);
            default: load_val = '0;
        endcase
    end

    assign blocked = !wp_n && is_prog && (int'(launch_page) < PROT_PAGES);
    assign start   = launch_valid && is_array && !busy && !blocked;

    fsb_op_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load_val (load_val),
        .busy     (busy),
        .done     (done)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (start) ctl_d.op = op_e'(launch_op);
        if (done && ctl_q.op == OP_CMP) ctl_d.cmp = cmp_mismatch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{op: OP_NONE, cmp: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign stat_low = {ctl_q.cmp, DENSITY_CODE, 2'b00};

    fsb_stat_shift u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (stat_load),
        .shift      (stat_shift),
        .status_low (stat_low),
        .ready_live (!busy),
        .bit_out    (stat_bit)
    );

    assign rdy_pull_oe = busy;

    // R6: the compare bit moves only when a compare finishes
    assert_cmp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && ctl_q.op == OP_CMP) |=> $stable(ctl_q.cmp));

    // R7: a protected program or erase never reaches the timer
    assert_wp_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && !wp_n && is_prog && int'(launch_page) < PROT_PAGES && !busy)
            |=> !busy);

    // R4: buffer-only and status codes never start an operation
    assert_bufonly_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && !is_array && !busy) |=> !busy);
endmodule

// File: tb/tb_flash_busy_ctrl.sv
module tb_flash_busy_ctrl;
    localparam int CX = 20, CEP = 60, CP = 50, CPE = 40, CBE = 45, PROT = 256;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       launch_valid = 1'b0, wp_n = 1'b1, cmp_mismatch = 1'b0;
    logic       stat_load = 1'b0, stat_shift = 1'b0;
    logic [3:0] launch_op = '0;
    logic [9:0] launch_page = '0;
    logic       stat_bit, rdy_pull_oe;

    flash_busy_ctrl #(.PAGE_W(10), .PROT_PAGES(PROT), .CYC_XFER(CX), .CYC_EP(CEP),
                      .CYC_PGM(CP), .CYC_PE(CPE), .CYC_BE(CBE)) dut (
        .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_op(launch_op),
        .launch_page(launch_page), .wp_n(wp_n), .cmp_mismatch(cmp_mismatch),
        .stat_load(stat_load), .stat_shift(stat_shift), .stat_bit(stat_bit),
        .rdy_pull_oe(rdy_pull_oe));

    always #10 clk = ~clk;

    int tests = 0, fails = 0;
    string cur_tag = "R2";

    bit       m_busy = 0, m_cmp = 0;
    int       m_left = 0, m_op = 0, m_idx = 7;
    bit [7:0] m_snap = 8'h00;

    function automatic int cyc_of(int op);
        case (op)
            1, 2, 9:  return CX;
            3, 7, 8:  return CEP;
            4:        return CP;
            5:        return CPE;
            6:        return CBE;
            default:  return 0;
        endcase
    endfunction

    function automatic bit is_prog(int op);
        return (op >= 3 && op <= 8);
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic step(bit v, int op, int pg, bit wp, bit cm, bit ld, bit sh);
        bit [7:0] st;
        bit       acc;
        launch_valid = v; launch_op = 4'(op); launch_page = 10'(pg);
        wp_n = wp; cmp_mismatch = cm; stat_load = ld; stat_shift = sh;
        st  = {~m_busy, m_cmp, 4'b0101, 2'b00};
        acc = v && cyc_of(op) != 0 && !m_busy && !(!wp && is_prog(op) && pg < PROT);
        if (ld) begin
            m_idx = 7; m_snap = st;
        end else if (sh) begin
            if (m_idx == 0) begin m_idx = 7; m_snap = st; end
            else m_idx--;
        end
        if (m_busy) begin
            if (m_left == 1) begin
                m_busy = 0;
                if (m_op == 2) m_cmp = cm;
            end else m_left--;
        end else if (acc) begin
            m_busy = 1; m_left = cyc_of(op); m_op = op;
        end
        @(posedge clk);
        @(negedge clk);
        check(rdy_pull_oe == m_busy, cur_tag, rdy_pull_oe, m_busy);
        check(stat_bit == ((m_idx == 7) ? ~m_busy : m_snap[m_idx]),
              (m_idx == 7) ? "R10" : "R8 R9", stat_bit,
              (m_idx == 7) ? ~m_busy : m_snap[m_idx]);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 1, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_busy = 0; m_cmp = 0; m_left = 0; m_op = 0; m_idx = 7; m_snap = 0;
        @(posedge clk); @(negedge clk);
        check(rdy_pull_oe == 1'b0, "R1 R11", rdy_pull_oe, 0);
        rst_n = 1'b1;
    endtask

    // Launch one command and count the cycles the pull-down is enabled
    task automatic measure(int op, int pg, bit wp, output int cnt);
        cnt = 0;
        step(1, op, pg, wp, 0, 0, 0);
        while (rdy_pull_oe && cnt < 500) begin
            cnt++;
            step(0, 0, 0, 1, 0, 0, 0);
        end
    endtask

    // Read a whole status byte through the serialiser and compare it
    task automatic read_byte(bit [7:0] expv, string tag);
        bit [7:0] got;
        step(0, 0, 0, 1, 0, 1, 0);
        got[7] = stat_bit;
        for (int b = 6; b >= 0; b--) begin
            step(0, 0, 0, 1, 0, 0, 1);
            got[b] = stat_bit;
        end
        check(got == expv, tag, got, expv);
        step(0, 0, 0, 1, 0, 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        cur_tag = "R1";
        do_reset();
        idle(2);
        read_byte(8'h94, "R1 R8");

        cur_tag = "R3";
        for (int op = 1; op <= 9; op++) begin
            measure(op, 600, 1, n);
            check(n == cyc_of(op), "R2 R3", n, cyc_of(op));
            idle(2);
        end

        cur_tag = "R4";
        for (int op = 10; op <= 15; op++) begin
            step(1, op, 5, 1, 0, 0, 0);
            check(rdy_pull_oe == 1'b0, "R4", rdy_pull_oe, 0);
        end
        step(1, 0, 5, 1, 0, 0, 0);
        check(rdy_pull_oe == 1'b0, "R4", rdy_pull_oe, 0);

        cur_tag = "R6";
        step(1, 2, 300, 1, 1, 0, 0);
        for (int i = 0; i < CX + 2; i++) step(0, 0, 0, 1, 1, 0, 0);
        read_byte(8'hD4, "R6 R8");

        cur_tag = "R5";
        step(1, 5, 700, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(1, 6, 700, 1, 0, 0, 0);
        step(1, 2, 700, 1, 0, 0, 0);
        n = 3;
        while (rdy_pull_oe && n < 500) begin n++; step(0, 0, 0, 1, 0, 0, 0); end
        check(n == CPE, "R5", n, CPE);
        read_byte(8'hD4, "R5 R6");

        cur_tag = "R7";
        measure(4, 255, 0, n);
        check(n == 0, "R7", n, 0);
        measure(5, 0, 0, n);
        check(n == 0, "R7", n, 0);
        measure(4, 256, 0, n);
        check(n == CP, "R7", n, CP);
        measure(2, 10, 0, n);
        check(n == CX, "R7", n, CX);
        measure(5, 10, 1, n);
        check(n == CPE, "R7", n, CPE);
        idle(CX + 2);
        read_byte(8'h94, "R6 R8");

        cur_tag = "R11";
        step(1, 3, 900, 1, 0, 0, 0);
        idle(5);
        do_reset();
        idle(1);
        check(rdy_pull_oe == 1'b0, "R11", rdy_pull_oe, 0);

        cur_tag = "R10";
        step(1, 1, 3, 1, 0, 1, 0);
        check(stat_bit == 1'b0, "R10", stat_bit, 0);
        idle(CX);
        check(stat_bit == 1'b1, "R10", stat_bit, 1);

        cur_tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            int pg = (r < 50) ? $urandom_range(250, 262) : $urandom_range(0, 1023);
            step($urandom_range(0, 3) == 0, $urandom_range(0, 15), pg,
                 $urandom_range(0, 1), $urandom_range(0, 1),
                 $urandom_range(0, 39) == 0, $urandom_range(0, 1));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule